// File: doc/BRIEF.md
# Digital Silence Flag with Noise Test Output

This block watches a stereo sample stream and raises a single output pin once both channels have carried nothing but zero for a long, fixed run of frames. The pin is meant to drive an external mute switch so that the analog path stays quiet during digital silence. A frame strobe marks each valid left/right sample pair. Data present while the strobe is low is not looked at.

The same pin doubles as a test output. A small register port holds an 8-bit test register. When that register holds one particular code, the pin stops showing the silence flag. It then carries the serial output of a free-running 24-bit maximal-length pseudo-random generator, which steps on an oversampled bit-rate enable. Such a stream serves as a white-noise stimulus for speaker or room measurements. Shaping or filtering of that stream happens elsewhere.

Top module: `zero_flag_test_out`

## Requirements
- R1: With the pin in flag mode, the output goes high in the cycle after the strobe of the 1024th consecutive strobed frame in which both samples are exactly zero. After 1023 such frames it is still low.
- R2: The silence run saturates at its terminal count, so the output stays high for any number of further all-zero frames and across cycles with no strobe.
- R3: A strobed frame with a nonzero sample on either channel clears the run. The output is low in the cycle after that strobe, and a fresh run of 1024 all-zero frames is needed before it rises again.
- R4: Sample inputs are ignored in cycles without a frame strobe. Nonzero data there neither clears nor advances the run.
- R5: The test register sits at register address 511 and is 8 bits wide. A write takes effect on the next cycle. Value 7 (8'h07) selects the noise output. Every other value selects the silence flag. Writes to any other address leave the register unchanged.
- R6: The noise generator is a 24-bit Fibonacci shift register s[23:0] with polynomial x^24+x^23+x^22+x^17+1. Its next state is {s[22:0], s[23]^s[22]^s[21]^s[16]}, and the pin shows s[23] in noise mode. It steps only in cycles where the bit enable is high, runs whether or not noise mode is selected, and its state is never all zero.
- R7: Reset clears the silence run and the test register, so the pin starts low in flag mode. Reset also loads the generator with the seed 24'h5A5A5A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle marker of a valid sample pair |
| left_smp | input | 24 | Left channel sample, twos complement |
| right_smp | input | 24 | Right channel sample, twos complement |
| bit_en | input | 1 | Noise bit-rate enable (128 times the frame rate in use) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register write address |
| reg_wdata | input | 8 | Register write data |
| flag_out | output | 1 | Silence flag, or noise bit when the test code is loaded |

## Verification
Every result appears one clock after its cause. The run counter, the test register and the generator state each update on the edge that samples the stimulus, and the pin is a combinational choice among them. The bench therefore drives stimulus on the falling edge, lets one rising edge pass, and checks the pin on the next falling edge. Its own model of the generator is stepped at that same rising edge whenever the enable was high. For the silence flag, each frame occupies one strobe cycle, and the pin is compared after every frame of a run, so an early or late rise by even one frame is caught.

// File: rtl/zf_pkg.sv
package zf_pkg;
  localparam int NOISE_W = 24;

  // Fibonacci step for x^24+x^23+x^22+x^17+1, shifting toward the MSB
  function automatic logic [NOISE_W-1:0] noise_step(input logic [NOISE_W-1:0] s);
    logic fb;
    fb = s[23] ^ s[22] ^ s[21] ^ s[16];
    return {s[NOISE_W-2:0], fb};
  endfunction

  // Saturating increment toward a terminal value
  function automatic int unsigned run_next(input int unsigned cur, input int unsigned term);
    return (cur >= term) ? term : cur + 1;
  endfunction
endpackage

// File: rtl/zf_silence_count.sv
module zf_silence_count #(
  parameter int SAMPLE_W = 24,
  parameter int FRAMES   = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_stb,
  input  logic [SAMPLE_W-1:0] left_smp,
  input  logic [SAMPLE_W-1:0] right_smp,
  output logic                silent_o
);
  localparam int CW = $clog2(FRAMES + 1);
  localparam logic [CW-1:0] TERM = CW'(FRAMES);

  logic [CW-1:0] run_q;
  logic both_zero, zero_frame, break_frame;

  assign both_zero   = (left_smp == '0) && (right_smp == '0);
  assign zero_frame  = frame_stb && both_zero;
  assign break_frame = frame_stb && !both_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else if (break_frame)
      run_q <= '0;
    else if (zero_frame)
      run_q <= CW'(zf_pkg::run_next(int'(run_q), FRAMES));
  end

  assign silent_o = (run_q == TERM);

  // R3
  break_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    break_frame |=> !silent_o);

  // R2
  flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (silent_o && !break_frame) |=> silent_o);

  // R1
  rise_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(silent_o) |-> $past(zero_frame));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(run_q));
endmodule

// File: rtl/zf_test_reg.sv
module zf_test_reg #(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int TEST_ADDR  = 511,
  parameter int NOISE_CODE = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              noise_sel_o
);
  logic [DATA_W-1:0] test_q;
  logic addr_hit;

  assign addr_hit = wr_en && (wr_addr == ADDR_W'(TEST_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      test_q <= '0;
    else if (addr_hit) test_q <= wr_data;
  end

  assign noise_sel_o = (test_q == DATA_W'(NOISE_CODE));

  // R5
  foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |=> $stable(test_q));

  // R5
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |=> (test_q == $past(wr_data)));
endmodule

// File: rtl/zf_noise_lfsr.sv
module zf_noise_lfsr #(
  parameter logic [23:0] SEED = 24'h5A5A5A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  output logic noise_bit_o
);
  import zf_pkg::*;

  logic [NOISE_W-1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= SEED;
    else if (step_en) state_q <= noise_step(state_q);
  end

  assign noise_bit_o = state_q[NOISE_W-1];

  initial begin
    // R6
    seed_nonzero_chk: assert (SEED != '0);
  end

  // R6
  never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(state_q));

  // R6
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> (state_q[NOISE_W-1:1] == $past(state_q[NOISE_W-2:0])));
endmodule

// File: rtl/zero_flag_test_out.sv
module zero_flag_test_out #(
  parameter int          SAMPLE_W       = 24,
  parameter int          SILENCE_FRAMES = 1024,
  parameter int          ADDR_W         = 9,
  parameter int          DATA_W         = 8,
  parameter int          TEST_ADDR      = 511,
  parameter int          NOISE_CODE     = 7,
  parameter logic [23:0] NOISE_SEED     = 24'h5A5A5A
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_stb,
  input  logic [SAMPLE_W-1:0] left_smp,
  input  logic [SAMPLE_W-1:0] right_smp,
  input  logic                bit_en,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic                flag_out
);
  logic silent_w;
  logic noise_sel_w;
  logic noise_bit_w;

  zf_silence_count #(.SAMPLE_W(SAMPLE_W), .FRAMES(SILENCE_FRAMES)) u_run (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
    .left_smp(left_smp), .right_smp(right_smp), .silent_o(silent_w));

  zf_test_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                .TEST_ADDR(TEST_ADDR), .NOISE_CODE(NOISE_CODE)) u_treg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .noise_sel_o(noise_sel_w));

  zf_noise_lfsr #(.SEED(NOISE_SEED)) u_noise (
    .clk(clk), .rst_n(rst_n), .step_en(bit_en), .noise_bit_o(noise_bit_w));

  assign flag_out = noise_sel_w ? noise_bit_w : silent_w;

  // R7
  reset_low_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> !flag_out);
endmodule

// File: tb/zero_flag_test_out_test.sv
`timescale 1ns/1ps
module zero_flag_test_out_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_stb = 1'b0;
  logic [23:0] left_smp = '0;
  logic [23:0] right_smp = '0;
  logic        bit_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        flag_out;

  int checks = 0;
  int errors = 0;
  logic [23:0] model = 24'h5A5A5A;
  localparam logic [23:0] TAP_MASK = 24'hE10000;

  always #4 clk = ~clk;

  zero_flag_test_out uut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .left_smp(left_smp),
    .right_smp(right_smp), .bit_en(bit_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .flag_out(flag_out));

  task automatic tick();
    @(posedge clk);
    if (!rst_n)      model = 24'h5A5A5A;
    else if (bit_en) model = {model[22:0], ^(model & TAP_MASK)};
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: flag_out=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic frame(input logic [23:0] l, input logic [23:0] r);
    frame_stb = 1'b1; left_smp = l; right_smp = r;
    tick();
    frame_stb = 1'b0; left_smp = '0; right_smp = '0;
  endtask

  task automatic write_reg(input logic [8:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  // run n all-zero frames, checking the pin after each against the expected run
  task automatic zero_run(input int start, input int n, input string req);
    for (int i = 1; i <= n; i++) begin
      frame(24'h0, 24'h0);
      check(req, flag_out, (start + i) >= 1024);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    check("R7 reset", flag_out, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    tick();
    check("R7 after release", flag_out, 1'b0);

    // R1: exact threshold
    zero_run(0, 1024, "R1 threshold");
    // R2: saturation and idle cycles
    zero_run(1024, 1500, "R2 saturate");
    repeat (20) tick();
    check("R2 idle hold", flag_out, 1'b1);

    // R4: nonzero data without a strobe
    left_smp = 24'h000001; right_smp = 24'h800000;
    repeat (6) begin tick(); check("R4 unstrobed data", flag_out, 1'b1); end
    left_smp = '0; right_smp = '0;

    // R3: left-only, right-only, partial runs
    frame(24'h000005, 24'h0);
    check("R3 left nonzero", flag_out, 1'b0);
    zero_run(0, 1024, "R3 rerun");
    frame(24'h0, 24'hFFFFFF);
    check("R3 right nonzero", flag_out, 1'b0);
    zero_run(0, 500, "R3 partial");
    frame(24'h0, 24'h000001);
    check("R3 partial break", flag_out, 1'b0);
    // R4: unstrobed zeros do not advance
    repeat (40) tick();
    zero_run(0, 1023, "R4 no advance");
    frame(24'h800000, 24'h800000);
    check("R3 both nonzero", flag_out, 1'b0);

    // R5: code 7 at a foreign address is ignored
    write_reg(9'd510, 8'd7);
    bit_en = 1'b1;
    repeat (60) begin tick(); check("R5 foreign addr", flag_out, 1'b0); end
    write_reg(9'd255, 8'd7);
    repeat (30) begin tick(); check("R5 foreign addr 255", flag_out, 1'b0); end

    // R5/R6: noise mode with an irregular enable
    write_reg(9'd511, 8'd7);
    for (int i = 0; i < 600; i++) begin
      bit_en = (i % 3 != 0) || (i % 7 == 0);
      tick();
      check("R6 noise bit", flag_out, model[23]);
    end
    bit_en = 1'b0;
    repeat (10) begin tick(); check("R6 hold without enable", flag_out, model[23]); end

    // R5: other values return to flag mode
    bit_en = 1'b1;
    write_reg(9'd511, 8'd6);
    repeat (40) begin tick(); check("R5 value 6", flag_out, 1'b0); end
    write_reg(9'd511, 8'h87);
    repeat (40) begin tick(); check("R5 value 0x87", flag_out, 1'b0); end
    write_reg(9'd511, 8'd7);
    repeat (200) begin tick(); check("R6 noise resumed", flag_out, model[23]); end
    write_reg(9'd511, 8'd0);
    zero_run(0, 1024, "R5 flag after noise");

    // R7: reset mid-run reseeds and clears
    rst_n = 1'b0;
    tick();
    check("R7 mid reset", flag_out, 1'b0);
    rst_n = 1'b1;
    bit_en = 1'b0;
    tick();
    check("R7 register cleared", flag_out, 1'b0);
    write_reg(9'd511, 8'd7);
    check("R7 seed bit", flag_out, 1'b0);
    bit_en = 1'b1;
    repeat (100) begin tick(); check("R7 seeded sequence", flag_out, model[23]); end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule